// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block connects a host processor, acting as SPI master, to a bank of 16-bit registers inside the chip. Each access is framed by an active-low chip select. The first byte the host sends is a header. Its top bit selects read or write, and its low six bits give the starting register. Every later pair of bytes moves one 16-bit register word, high byte first. The address advances by one after each word, so one transaction can cover several consecutive registers.

Data moves in one direction only. During a write the port listens on MOSI and drives MISO low. During a read it sends register contents on MISO and ignores MOSI. The SPI pins are sampled into the core clock domain through two flip-flop stages, and SCLK edges are detected there. A partial word left over when chip select rises is thrown away.

When chip select is high, an enable input chooses whether MISO floats (high impedance) or is driven low. On the register side the port offers one-cycle read and write strobes, a 6-bit address, write data, and read data that is combinational and returned in the same cycle.

Top module: `spi_regport`

## Requirements
- R1: While `spi_cs_n` is high, framing is held in its start state. Each fall of `spi_cs_n` starts a new transaction whose first byte is a header, even if the previous transaction was cut short.
- R2: Bits are sampled on rising SCLK, MSB first (SPI mode 0). In the header, bit 7 set means read and clear means write. Bits 5:0 are the register address. Bit 6 is ignored.
- R3: In a write, each completed pair of payload bytes gives exactly one `reg_wr` pulse. `reg_wdata` is {first byte, second byte}. The pulse is high in the third core clock after the synchroniser input sees the 16th rising SCLK of the word.
- R4: The word address starts at the header address and steps by one after every word. It wraps from 63 to 0.
- R5: In a read, `reg_rd` pulses once when the header completes and once after each payload word. `reg_rdata` is taken in the strobe cycle and shifted out MSB first on MISO. MISO changes after falling SCLK, so the MSB is valid before the first rising edge of the word.
- R6: No full duplex. During the header and during a write, MISO is driven 0. During a read, MOSI data never causes a write.
- R7: If chip select rises partway through a byte or a word, that partial word is discarded and no `reg_wr` is issued for it.
- R8: While chip select is low, `spi_miso_oe` is 1. While chip select is high, `spi_miso` is 0, and `spi_miso_oe` equals the inverse of `idle_hiz_en`. At reset the SPI inputs read as idle (chip select high).
- R9: `reg_wr` and `reg_rd` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| idle_hiz_en | input | 1 | 1: MISO floats while idle; 0: MISO is driven low while idle |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 6 | Register address for the current strobe |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, valid in the `reg_rd` cycle |

## Verification
Every effect of an SCLK edge lands a fixed number of core clocks after the pin changes. It takes two synchroniser stages, then one register stage. A write strobe is therefore seen three core clocks after the 16th rising edge of a word, and the bench measures this count directly. The MISO bit and the read-data load also settle within three or four clocks, so the bench holds each SCLK phase for six core clocks. It samples MISO just before it raises SCLK, and reads the strobes on the falling core clock. The idle-state checks are made several clocks after chip select moves, which covers the two-stage delay on chip select.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } spi_phase_e;

  localparam int HDR_RD_POS = 7;

  function automatic logic [7:0] byte_shift(input logic [6:0] held, input logic b);
    return {held, b};
  endfunction

  function automatic logic [5:0] addr_step(input logic [5:0] a);
    return a + 6'd1;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W   = 3,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= RST[i];
        st2 <= RST[i];
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regport_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          mosi_b,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          rd_phase,
  output logic          byte_done
);
  localparam int BPW = DW / 8;
  localparam int BCW = (BPW > 1) ? $clog2(BPW) : 1;

  spi_phase_e      phase;
  logic [2:0]      bitcnt;
  logic [BCW-1:0]  bytecnt;
  logic [6:0]      shreg;
  logic [DW-9:0]   word_acc;
  logic [AW-1:0]   cur_addr;

  logic [7:0]      sh_nxt;
  logic [DW-1:0]   wacc_nxt;
  logic            word_last;

  assign sh_nxt    = byte_shift(shreg, mosi_b);
  assign wacc_nxt  = {word_acc, sh_nxt};
  assign word_last = (bytecnt == BCW'(BPW - 1));
  assign byte_done = cs_act && sclk_rise && (bitcnt == 3'd7);
  assign rd_phase  = (phase == PH_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_HDR;
      bitcnt    <= '0;
      bytecnt   <= '0;
      shreg     <= '0;
      word_acc  <= '0;
      cur_addr  <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (!cs_act) begin
        phase   <= PH_HDR;
        bitcnt  <= '0;
        bytecnt <= '0;
      end else if (sclk_rise) begin
        shreg  <= sh_nxt[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (phase == PH_HDR) begin
            bytecnt <= '0;
            if (sh_nxt[HDR_RD_POS]) begin
              phase    <= PH_RD;
              reg_rd   <= 1'b1;
              reg_addr <= sh_nxt[AW-1:0];
              cur_addr <= AW'(addr_step(6'(sh_nxt[AW-1:0])));
            end else begin
              phase    <= PH_WR;
              cur_addr <= sh_nxt[AW-1:0];
            end
          end else begin
            word_acc <= wacc_nxt[DW-9:0];
            if (word_last) begin
              bytecnt  <= '0;
              reg_addr <= cur_addr;
              cur_addr <= AW'(addr_step(6'(cur_addr)));
              if (phase == PH_WR) begin
                reg_wr    <= 1'b1;
                reg_wdata <= wacc_nxt;
              end else begin
                reg_rd <= 1'b1;
              end
            end else begin
              bytecnt <= bytecnt + BCW'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_txshift.sv
module spi_txshift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sclk_fall,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  input  logic          rd_phase,
  output logic          miso_q
);
  logic [DW-1:0] txq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq    <= '0;
      miso_q <= 1'b0;
    end else if (!cs_act) begin
      txq    <= '0;
      miso_q <= 1'b0;
    end else if (load) begin
      txq <= ldata;
    end else if (sclk_fall) begin
      if (rd_phase) begin
        miso_q <= txq[DW-1];
        txq    <= {txq[DW-2:0], 1'b0};
      end else begin
        miso_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sclk,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          idle_hiz_en,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  logic [2:0] sync_q;
  logic       sclk_d;
  logic       cs_act, sclk_s, mosi_s;
  logic       sclk_rise, sclk_fall;
  logic       rd_phase, byte_done, miso_q;

  spi_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sclk, spi_mosi}),
    .q(sync_q)
  );

  assign cs_act = ~sync_q[2];
  assign sclk_s = sync_q[1];
  assign mosi_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  spi_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .mosi_b(mosi_s), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_phase(rd_phase), .byte_done(byte_done)
  );

  spi_txshift #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .load(reg_rd), .ldata(reg_rdata), .rd_phase(rd_phase), .miso_q(miso_q)
  );

  assign spi_miso    = cs_act ? miso_q : 1'b0;
  assign spi_miso_oe = cs_act | ~idle_hiz_en;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic sclk_rise,
  input logic rd_phase,
  input logic byte_done,
  input logic reg_wr,
  input logic reg_rd,
  input logic spi_miso,
  input logic spi_miso_oe,
  input logic idle_hiz_en
);
  // R9
  strb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  // R9
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  // R3
  wr_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(byte_done));
  // R5
  rd_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $past(sclk_rise));
  // R7
  wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(cs_act));
  // R8
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && idle_hiz_en) |-> !spi_miso_oe);
  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> (spi_miso == 1'b0));
  // R8
  active_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act |-> spi_miso_oe);
  // R6
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !rd_phase) |-> (spi_miso == 1'b0));
endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
  .rd_phase(rd_phase), .byte_done(byte_done), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
  .idle_hiz_en(idle_hiz_en)
);

// File: tb/spi_regport_tb.sv
module spi_regport_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cs_n, sclk, mosi, hiz;
  logic        miso, oe, wr, rd;
  logic [5:0]  addr;
  logic [15:0] wdata, rdata;
  logic [15:0] bank [64];
  int          wr_cnt, rd_cnt, checks, errors;
  logic [5:0]  last_wa;
  logic [15:0] last_wd;
  bit          strobe_bad, prev_wr, miso_nz;

  spi_regport u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .idle_hiz_en(hiz), .reg_wr(wr),
    .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
  );

  assign rdata = bank[addr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr) begin
        bank[addr] <= wdata;
        wr_cnt  <= wr_cnt + 1;
        last_wa <= addr;
        last_wd <= wdata;
      end
      if (rd) rd_cnt <= rd_cnt + 1;
      if ((wr && rd) || (wr && prev_wr)) strobe_bad <= 1'b1;
      prev_wr <= wr;
    end
  end

  function automatic logic [15:0] pat(input int a);
    logic [15:0] v;
    v = 16'(a) * 16'h0407;
    return v ^ 16'h5AC3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cs_start();
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (H) @(negedge clk); cs_n = 1'b1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] t, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = t[i];
      repeat (H) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    xbits(t, 8, r);
  endtask

  task automatic wr_word_txn(input logic [7:0] hdr, input logic [15:0] v);
    logic [7:0] r;
    cs_start();
    xbyte(hdr, r);          if (r != 0) miso_nz = 1'b1;
    xbyte(v[15:8], r);      if (r != 0) miso_nz = 1'b1;
    xbyte(v[7:0], r);       if (r != 0) miso_nz = 1'b1;
    cs_end();
  endtask

  task automatic rd_word(input int a, output logic [15:0] v);
    logic [7:0] hi, lo, r;
    cs_start();
    xbyte(8'h80 | 8'(a), r);
    xbyte(8'hFF, hi);
    xbyte(8'hFF, lo);
    cs_end();
    v = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  hi, lo, r;
    int          w0, r0, lat;
    for (int i = 0; i < 64; i++) bank[i] = '0;
    checks = 0; errors = 0; wr_cnt = 0; rd_cnt = 0;
    strobe_bad = 0; prev_wr = 0; miso_nz = 0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; hiz = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset / idle state
    chk(oe == 1'b0, "R8 idle hiz oe", 32'(oe), 0);
    chk(wr == 1'b0 && rd == 1'b0, "R9 reset strobes", {wr, rd}, 0);
    hiz = 1'b0; @(negedge clk);
    chk(oe == 1'b1 && miso == 1'b0, "R8 idle driven low", {oe, miso}, 2);

    // R2 R3 R4: single-word write to every address
    for (int a = 0; a < 64; a++) begin
      w0 = wr_cnt;
      wr_word_txn(8'(a), pat(a));
      chk(wr_cnt == w0 + 1 && last_wa == 6'(a) && last_wd == pat(a),
          "R3 write word", {10'(wr_cnt - w0), last_wa, last_wd}, {10'd1, 6'(a), pat(a)});
    end
    chk(!miso_nz, "R6 miso low during write", 32'(miso_nz), 0);

    // R5 R4 R6: one long read, 65 words, wraps 63->0, MOSI held high
    w0 = wr_cnt; r0 = rd_cnt;
    cs_start();
    chk(oe == 1'b1, "R8 active drive", 32'(oe), 1);
    xbyte(8'h80, r);
    for (int w = 0; w < 65; w++) begin
      xbyte(8'hFF, hi);
      xbyte(8'hFF, lo);
      chk({hi, lo} == pat(w % 64), "R5 read word", {hi, lo}, pat(w % 64));
    end
    cs_end();
    chk(rd_cnt == r0 + 66, "R5 read strobe count", 32'(rd_cnt - r0), 66);
    chk(wr_cnt == w0, "R6 mosi ignored in read", 32'(wr_cnt - w0), 0);

    // R2: header bit 6 ignored
    wr_word_txn(8'h40 | 8'd10, 16'h1234);
    rd_word(10, v);
    chk(v == 16'h1234, "R2 reserved bit ignored", v, 16'h1234);

    // R3 latency: strobe in third core clock after last rising edge
    cs_start();
    xbyte(8'd33, r);
    xbyte(8'hBE, r);
    xbits(8'hEF, 7, r);
    mosi = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b1; lat = 0;
    for (int k = 1; k <= H; k++) begin
      @(negedge clk);
      if (wr && lat == 0) lat = k;
    end
    sclk = 1'b0;
    cs_end();
    chk(lat == 3, "R3 strobe latency", 32'(lat), 3);
    rd_word(33, v);
    chk(v == 16'hBEEF, "R3 latency word data", v, 16'hBEEF);

    // R4: burst write wrapping 62,63,0
    w0 = wr_cnt;
    cs_start();
    xbyte(8'd62, r);
    xbyte(8'hA1, r); xbyte(8'hB2, r);
    xbyte(8'hC3, r); xbyte(8'hD4, r);
    xbyte(8'hE5, r); xbyte(8'hF6, r);
    cs_end();
    chk(wr_cnt == w0 + 3, "R4 burst write count", 32'(wr_cnt - w0), 3);
    rd_word(62, v); chk(v == 16'hA1B2, "R4 burst addr 62", v, 16'hA1B2);
    rd_word(63, v); chk(v == 16'hC3D4, "R4 burst addr 63", v, 16'hC3D4);
    rd_word(0, v);  chk(v == 16'hE5F6, "R4 burst wrap to 0", v, 16'hE5F6);

    // R7 R1: abort mid-byte of second payload byte
    w0 = wr_cnt;
    cs_start();
    xbyte(8'd5, r);
    xbyte(8'hAB, r);
    xbits(8'hCD, 4, r);
    cs_end();
    chk(wr_cnt == w0, "R7 abort mid byte", 32'(wr_cnt - w0), 0);
    rd_word(5, v);
    chk(v == pat(5), "R1 reg kept after abort", v, pat(5));

    // R7: abort after one full word plus one byte
    w0 = wr_cnt;
    cs_start();
    xbyte(8'd20, r);
    xbyte(8'h11, r); xbyte(8'h22, r);
    xbyte(8'h33, r);
    cs_end();
    chk(wr_cnt == w0 + 1 && last_wa == 6'd20, "R7 abort mid word",
        {10'(wr_cnt - w0), last_wa}, {10'd1, 6'd20});
    rd_word(21, v);
    chk(v == pat(21), "R7 partial word dropped", v, pat(21));

    // R1: abort inside header then a clean write
    cs_start();
    xbits(8'h80, 3, r);
    cs_end();
    wr_word_txn(8'd40, 16'h0F0F);
    rd_word(40, v);
    chk(v == 16'h0F0F, "R1 reframe after header abort", v, 16'h0F0F);

    // R8 back to high impedance
    hiz = 1'b1; @(negedge clk);
    chk(oe == 1'b0 && miso == 1'b0, "R8 idle hiz again", {oe, miso}, 0);
    chk(!strobe_bad, "R9 strobe pulses", 32'(strobe_bad), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule